// File: doc/BRIEF.md
# Coarse-to-fine correlation peak locator

This controller drives a bank of parallel correlators so that the column holding the strongest correlation can be found across a reference image wider than any one correlator. Each pass hands every correlator a starting column. The columns are spaced at a fixed stride, so neighbouring slices overlap. When all scores have come back, the controller finds the best slice and decides which of its two neighbours scored higher. It then lays a finer grid over the span between the two, and repeats. A pass run at a stride of one pixel is the last one. It yields the peak column, the row offset that the winning correlator reported and the peak score.

The first pass spreads the correlators evenly across the image width. Each later pass divides the stride by the number of correlators, and never goes below one pixel. With the defaults (16 correlators, 256 columns) the first pass uses stride 16 and the second pass uses stride 1, so a search takes two passes. The correlators and the loading of image data sit outside this block. Each correlator is started by a one-cycle go pulse, and all of them return their results together with a single valid pulse.

Top module: `cps_peak_search`

## Requirements
- R1: After reset, busy_o, done_o and corr_go_o are 0, and peak_col_o, peak_row_o and peak_val_o are 0.
- R2: A start_i accepted while idle raises busy_o and, one cycle later, produces a one-cycle corr_go_o with correlator k (field corr_off_o[k*COL_W +: COL_W]) given column k*IMG_W/N_CORR.
- R3: Scores are unsigned. The winning slot of a pass is the one with the largest score, and when scores are equal the lowest slot index wins.
- R4: After a pass whose stride s is above 1, the next stride is max(1, s/N_CORR), written s2. Let c be the winner's column and w its slot index. If w is 0, or if the right neighbour's score is strictly higher than the left neighbour's, the next pass starts at c. Otherwise (w is the last slot, or the left neighbour scores at least as high) it starts at c-(N_CORR-1)*s2, or at 0 if that would be negative. Slot k then gets start+k*s2.
- R5: A pass run at stride 1 is the last pass. For the default parameters every search therefore issues exactly two go pulses. peak_col_o is the winner's column, and peak_row_o and peak_val_o are the row and score that the winning slot reported.
- R6: In every pass, the next corr_go_o or the done_o pulse rises on the (log2(N_CORR)+1)-th rising edge after the edge that samples corr_valid_i. done_o lasts one cycle and coincides with busy_o falling.
- R7: start_i has no effect while busy_o is 1. The search in progress gives the same passes and the same result.
- R8: Between done pulses the peak outputs hold their values, and a corr_valid_i pulse while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (only honoured when idle) |
| busy_o | output | 1 | Search in progress |
| corr_go_o | output | 1 | One-cycle start pulse to all correlators |
| corr_off_o | output | N_CORR*COL_W | Start column for each correlator, slot k at bits k*COL_W |
| corr_valid_i | input | 1 | All correlator results present this cycle |
| corr_score_i | input | N_CORR*SCORE_W | Peak score per slot |
| corr_row_i | input | N_CORR*ROW_W | Row offset of each slot's peak |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| peak_col_o | output | COL_W | Column of the overall peak |
| peak_row_o | output | ROW_W | Row offset of the overall peak |
| peak_val_o | output | SCORE_W | Score of the overall peak |

## Verification
The bench stands in for the correlators. It reads the start columns on the falling edge on which corr_go_o is seen, answers two cycles later with scores drawn from a profile whose peak is known, and counts falling edges from the one on which it drops corr_valid_i. After the default four-level compare tree, the next go pulse or the done pulse must appear on the sixth of those falling edges. The bench checks the done pulse at that exact count, then confirms that it has cleared one falling edge later. The peak column, row and value are read on the same falling edge as done, and the second-pass start column is read on the falling edge of the second go pulse.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_TREE,
    S_PICK
  } cps_state_e;
endpackage

// File: rtl/cps_slicer.sv
module cps_slicer #(
  parameter int N_CORR = 16,
  parameter int COL_W  = 8
) (
  input  logic [COL_W-1:0]        base_i,
  input  logic [COL_W-1:0]        step_i,
  output logic [N_CORR*COL_W-1:0] off_o
);
  for (genvar k = 0; k < N_CORR; k++) begin : g_slot
    localparam logic [COL_W-1:0] KV = COL_W'(k);
    assign off_o[k*COL_W +: COL_W] = base_i + KV * step_i;
  end
endmodule

// File: rtl/cps_max_tree.sv
module cps_max_tree #(
  parameter int N_CORR  = 16,
  parameter int SCORE_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORR*SCORE_W-1:0] score_i,
  output logic [SCORE_W-1:0]        best_score_o,
  output logic [IDX_W-1:0]          best_idx_o
);
  for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
    localparam int W = N_CORR >> l;
    logic [SCORE_W-1:0] s [W];
    logic [IDX_W-1:0]   x [W];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_in
        assign s[j] = score_i[j*SCORE_W +: SCORE_W];
        assign x[j] = IDX_W'(j);
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        // right child only wins when strictly larger: lower index keeps ties
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            s[j] <= '0;
            x[j] <= '0;
          end else if (g_lvl[l-1].s[2*j+1] > g_lvl[l-1].s[2*j]) begin
            s[j] <= g_lvl[l-1].s[2*j+1];
            x[j] <= g_lvl[l-1].x[2*j+1];
          end else begin
            s[j] <= g_lvl[l-1].s[2*j];
            x[j] <= g_lvl[l-1].x[2*j];
          end
        end
      end
    end
  end

  assign best_score_o = g_lvl[IDX_W].s[0];
  assign best_idx_o   = g_lvl[IDX_W].x[0];
endmodule

// File: rtl/cps_pair_pick.sv
module cps_pair_pick #(
  parameter int N_CORR  = 16,
  parameter int SCORE_W = 32,
  parameter int COL_W   = 8,
  parameter int IDX_W   = 4
) (
  input  logic [N_CORR*SCORE_W-1:0] score_i,
  input  logic [IDX_W-1:0]          win_i,
  input  logic [COL_W-1:0]          base_i,
  input  logic [COL_W-1:0]          step_i,
  output logic [COL_W-1:0]          win_col_o,
  output logic [COL_W-1:0]          next_base_o,
  output logic [COL_W-1:0]          next_step_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CORR - 1);
  localparam logic [COL_W-1:0] NM1  = COL_W'(N_CORR - 1);

  logic [SCORE_W-1:0] sc [N_CORR];
  logic [SCORE_W-1:0] sc_l, sc_r;
  logic [COL_W-1:0]   fine, span;
  logic               go_left;

  for (genvar k = 0; k < N_CORR; k++) begin : g_unpack
    assign sc[k] = score_i[k*SCORE_W +: SCORE_W];
  end

  always_comb begin
    fine = step_i >> IDX_W;
    if (fine == '0) fine = COL_W'(1);
    win_col_o = base_i + COL_W'(win_i) * step_i;
    sc_l = (win_i == '0)  ? '0 : sc[win_i - IDX_W'(1)];
    sc_r = (win_i == LAST) ? '0 : sc[win_i + IDX_W'(1)];
    if (win_i == '0)        go_left = 1'b0;
    else if (win_i == LAST) go_left = 1'b1;
    else                    go_left = (sc_l >= sc_r);
    span = NM1 * fine;
    if (!go_left)              next_base_o = win_col_o;
    else if (win_col_o < span) next_base_o = '0;
    else                       next_base_o = win_col_o - span;
    next_step_o = fine;
  end
endmodule

// File: rtl/cps_peak_search.sv
module cps_peak_search #(
  parameter int N_CORR  = 16,
  parameter int IMG_W   = 256,
  parameter int SCORE_W = 32,
  parameter int ROW_W   = 9,
  localparam int COL_W  = $clog2(IMG_W),
  localparam int IDX_W  = $clog2(N_CORR)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      corr_go_o,
  output logic [N_CORR*COL_W-1:0]   corr_off_o,
  input  logic                      corr_valid_i,
  input  logic [N_CORR*SCORE_W-1:0] corr_score_i,
  input  logic [N_CORR*ROW_W-1:0]   corr_row_i,
  output logic                      done_o,
  output logic [COL_W-1:0]          peak_col_o,
  output logic [ROW_W-1:0]          peak_row_o,
  output logic [SCORE_W-1:0]        peak_val_o
);
  import cps_pkg::*;

  localparam logic [COL_W-1:0] FIRST_STEP = COL_W'(IMG_W / N_CORR);
  localparam int               CNT_W      = $clog2(IDX_W + 1);
  localparam logic [CNT_W-1:0] TREE_END   = CNT_W'(IDX_W - 1);

  cps_state_e                state_q;
  logic [COL_W-1:0]          base_q, step_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [N_CORR*SCORE_W-1:0] cap_score_q;
  logic [N_CORR*ROW_W-1:0]   cap_row_q;
  logic [SCORE_W-1:0]        best_score;
  logic [IDX_W-1:0]          best_idx;
  logic [COL_W-1:0]          win_col, next_base, next_step;

  cps_slicer #(.N_CORR(N_CORR), .COL_W(COL_W)) i_slicer (
    .base_i (base_q),
    .step_i (step_q),
    .off_o  (corr_off_o)
  );

  cps_max_tree #(.N_CORR(N_CORR), .SCORE_W(SCORE_W), .IDX_W(IDX_W)) i_tree (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .score_i      (cap_score_q),
    .best_score_o (best_score),
    .best_idx_o   (best_idx)
  );

  cps_pair_pick #(.N_CORR(N_CORR), .SCORE_W(SCORE_W), .COL_W(COL_W), .IDX_W(IDX_W)) i_pick (
    .score_i     (cap_score_q),
    .win_i       (best_idx),
    .base_i      (base_q),
    .step_i      (step_q),
    .win_col_o   (win_col),
    .next_base_o (next_base),
    .next_step_o (next_step)
  );

  assign busy_o    = (state_q != S_IDLE);
  assign corr_go_o = (state_q == S_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      base_q      <= '0;
      step_q      <= '0;
      cnt_q       <= '0;
      cap_score_q <= '0;
      cap_row_q   <= '0;
      done_o      <= 1'b0;
      peak_col_o  <= '0;
      peak_row_o  <= '0;
      peak_val_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          base_q  <= '0;
          step_q  <= FIRST_STEP;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (corr_valid_i) begin
          cap_score_q <= corr_score_i;
          cap_row_q   <= corr_row_i;
          cnt_q       <= '0;
          state_q     <= S_TREE;
        end
        S_TREE: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == TREE_END) state_q <= S_PICK;
        end
        S_PICK: begin
          if (step_q == COL_W'(1)) begin
            peak_col_o <= win_col;
            peak_val_o <= best_score;
            peak_row_o <= cap_row_q[best_idx*ROW_W +: ROW_W];
            done_o     <= 1'b1;
            state_q    <= S_IDLE;
          end else begin
            base_q  <= next_base;
            step_q  <= next_step;
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cps_peak_search_chk.sv
module cps_peak_search_chk #(
  parameter int N_CORR  = 16,
  parameter int IMG_W   = 256,
  parameter int SCORE_W = 32,
  parameter int ROW_W   = 9,
  localparam int COL_W  = $clog2(IMG_W)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    corr_go_o,
  input logic [N_CORR*COL_W-1:0] corr_off_o,
  input logic                    done_o,
  input logic [COL_W-1:0]        peak_col_o,
  input logic [ROW_W-1:0]        peak_row_o,
  input logic [SCORE_W-1:0]      peak_val_o
);
  localparam logic [COL_W-1:0] STRIDE0 = COL_W'(IMG_W / N_CORR);

  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_go_o |=> !corr_go_o);  // R2
  AST_GO_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_go_o |-> busy_o);  // R2
  AST_FIRST_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_go_o && $past(start_i && !busy_o)) |->
      (corr_off_o[COL_W-1:0] == '0 && corr_off_o[2*COL_W-1:COL_W] == STRIDE0));  // R2
  AST_OFF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_go_o |=> $stable(corr_off_o));  // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));  // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(peak_col_o) && $stable(peak_row_o) && $stable(peak_val_o)));  // R8
endmodule

bind cps_peak_search cps_peak_search_chk #(
  .N_CORR(N_CORR), .IMG_W(IMG_W), .SCORE_W(SCORE_W), .ROW_W(ROW_W)
) i_chk (.*);

// File: tb/test_cps_peak_search.sv
`timescale 1ns/1ps
module test_cps_peak_search;
  localparam int N = 16, W = 256, SW = 32, RW = 9, CW = 8, LOGN = 4;

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, corr_valid_i = 1'b0;
  logic          busy_o, corr_go_o, done_o;
  logic [N*CW-1:0] corr_off_o;
  logic [N*SW-1:0] corr_score_i = '0;
  logic [N*RW-1:0] corr_row_i = '0;
  logic [CW-1:0] peak_col_o;
  logic [RW-1:0] peak_row_o;
  logic [SW-1:0] peak_val_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  cps_peak_search i_cps_peak_search (.*);

  // peak column, slope, row seed, poke start while busy
  localparam int VEC [7][4] = '{
    '{128, 5, 11, 0}, '{37, 3, 4, 0}, '{255, 2, 100, 0}, '{0, 7, 9, 0},
    '{200, 0, 50, 0}, '{91, 1, 3, 1}, '{170, 4, 77, 0}};

  function automatic int prof(int p, int k, int off);
    int d = (off > p) ? off - p : p - off;
    return 100000 - k * d;
  endfunction

  function automatic int rowf(int off, int seed);
    return (off * 3 + seed) % 512;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int p, input int k, output int col, output int base2);
    int base = 0, step = W / N, w = 0, best, s, ws, ns, sl, sr;
    bit left;
    base2 = -1;
    forever begin
      best = -1;
      for (int kk = 0; kk < N; kk++) begin
        s = prof(p, k, base + kk * step);
        if (s > best) begin best = s; w = kk; end
      end
      if (step == 1) begin col = base + w; return; end
      ns = step / N; if (ns == 0) ns = 1;
      ws = base + w * step;
      sl = (w > 0) ? prof(p, k, ws - step) : 0;
      sr = (w < N - 1) ? prof(p, k, ws + step) : 0;
      left = (w == N - 1) || (w != 0 && sl >= sr);
      base = left ? ((ws < (N - 1) * ns) ? 0 : ws - (N - 1) * ns) : ws;
      step = ns;
      base2 = base;
    end
  endtask

  task automatic run_search(input int p, input int k, input int seed, input bit poke,
                            output int passes, output int off2, output int lat);
    int offs [N];
    int guard;
    bit fin = 0;
    passes = 0; off2 = -1; lat = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    while (!fin) begin
      guard = 0;
      while (!corr_go_o && guard < 50) begin @(negedge clk_i); guard++; end
      if (!corr_go_o) begin chk(0, "R2 go missing", 0, 1); return; end
      passes++;
      for (int kk = 0; kk < N; kk++) offs[kk] = int'(corr_off_o[kk*CW +: CW]);
      if (passes == 1)
        for (int kk = 0; kk < N; kk++)
          chk(offs[kk] == kk * (W / N), "R2 first offsets", offs[kk], kk * (W / N));
      if (passes == 2) off2 = offs[0];
      @(negedge clk_i) if (poke) start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      corr_valid_i = 1'b1;
      for (int kk = 0; kk < N; kk++) begin
        corr_score_i[kk*SW +: SW] = SW'(prof(p, k, offs[kk]));
        corr_row_i[kk*RW +: RW]   = RW'(rowf(offs[kk], seed));
      end
      @(negedge clk_i) corr_valid_i = 1'b0;
      lat = 1;
      while (!corr_go_o && !done_o && lat < 50) begin @(negedge clk_i); lat++; end
      chk(lat == LOGN + 2, "R6 pass latency", lat, LOGN + 2);
      if (done_o || passes >= 4) fin = 1;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int passes, off2, lat, ecol, ebase2, hc, hr, hv;
    #12;
    chk(!busy_o && !done_o && !corr_go_o, "R1 reset controls", {busy_o, done_o, corr_go_o}, 0);
    chk(peak_col_o == 0 && peak_val_o == 0 && peak_row_o == 0, "R1 reset outputs",
        int'(peak_val_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !corr_go_o, "R1 idle after reset", {busy_o, corr_go_o}, 0);

    foreach (VEC[i]) begin
      model(VEC[i][0], VEC[i][1], ecol, ebase2);
      run_search(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3] != 0, passes, off2, lat);
      chk(done_o == 1'b1, "R6 done seen", int'(done_o), 1);
      chk(passes == 2, VEC[i][3] ? "R7 passes with start poke" : "R5 pass count", passes, 2);
      chk(off2 == ebase2, "R4 second pass start", off2, ebase2);
      chk(int'(peak_col_o) == ecol, VEC[i][1] == 0 ? "R3 tie column" : "R5 peak column",
          int'(peak_col_o), ecol);
      chk(int'(peak_row_o) == rowf(ecol, VEC[i][2]), "R5 peak row", int'(peak_row_o),
          rowf(ecol, VEC[i][2]));
      chk(int'(peak_val_o) == prof(VEC[i][0], VEC[i][1], ecol), "R5 peak value",
          int'(peak_val_o), prof(VEC[i][0], VEC[i][1], ecol));
      chk(!busy_o, "R6 idle at done", int'(busy_o), 0);
      @(negedge clk_i);
      chk(!done_o, "R6 done one cycle", int'(done_o), 1'b0);
    end

    // directed: tie-left rule puts the window end on the winner
    model(128, 5, ecol, ebase2);
    chk(ebase2 == 113 && ecol == 128, "R4 tie toward left model", ebase2, 113);

    // directed: results hold, stray valid while idle ignored
    hc = int'(peak_col_o); hr = int'(peak_row_o); hv = int'(peak_val_o);
    repeat (5) @(negedge clk_i);
    corr_valid_i = 1'b1;
    corr_score_i = '1;
    @(negedge clk_i) corr_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(!busy_o && !corr_go_o && !done_o, "R8 stray valid idle", int'(busy_o), 0);
    chk(int'(peak_col_o) == hc, "R8 column held", int'(peak_col_o), hc);
    chk(int'(peak_row_o) == hr && int'(peak_val_o) == hv, "R8 row value held",
        int'(peak_val_o), hv);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule